// File: doc/BRIEF.md
# Integer ALU with Status Flag Generation

A purely combinational arithmetic and logic unit that works on byte, halfword and word operands. It executes bitwise OR, AND and XOR, addition, subtraction, increment and decrement. It returns the result together with six status flags: carry, overflow, sign, zero, parity and half-carry.

An execution stage presents an operation code, a size select, the two operands and the current flag vector. It takes the result and the updated flag vector in the same cycle. Flags that an operation does not define are copied from the incoming vector, so the caller can write the whole flag vector back every time.

Each flag rule is evaluated at the selected width. The one exception is parity, which only ever looks at the low byte. Increment and decrement keep the incoming carry. The bitwise operations force carry and overflow low.

Top module: `alu_flags_core`

## Requirements
- R1: Encodings. `op_i` selects 0 OR, 1 AND, 2 XOR, 3 ADD, 4 SUB (dst minus src), 5 INC, 6 DEC and 7 HOLD. `size_i` selects 0 for 8 bits, 1 for 16 bits and 2 for 32 bits. The flag vectors place CF at bit 0, PF at bit 1, AF at bit 2, ZF at bit 3, SF at bit 4 and OF at bit 5.
- R2: ADD returns dst+src truncated to the width. CF is the carry out of the top bit of that width.
- R3: ADD sets OF when the top bit of ((result^src) & (result^dst)) is 1 at the selected width.
- R4: SUB returns dst-src truncated to the width. CF is the borrow, i.e. bit 8, 16 or 32 of the widened difference. OF is the top bit of ((dst^src) & (dst^result)).
- R5: For ADD, SUB, INC and DEC, AF is bit 4 of (result^src^dst), where src is 1 for INC and DEC.
- R6: PF is 1 when the low 8 bits of the result hold an even number of ones, for every width.
- R7: ZF is 1 when the result at the selected width is zero. SF is the top bit at that width.
- R8: OR, AND and XOR drive CF and OF to 0, set SF, ZF and PF from the result, and copy AF from `flags_i`.
- R9: INC and DEC behave as ADD and SUB of 1 for OF, AF, SF, ZF and PF. They copy CF from `flags_i` even when the value wraps. `src_i` is ignored.
- R10: For every operation except HOLD, result bits above the selected width are 0, whatever the upper operand bits are.
- R11: HOLD returns `dst_i` unchanged on all 32 bits and copies `flags_i` to `flags_o`.
- R12: `size_i` = 3 behaves exactly as the 32-bit size.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 3 | Operation code (R1) |
| size_i | input | 2 | Operand width select (R1) |
| dst_i | input | 32 | Destination operand, the minuend for SUB and DEC |
| src_i | input | 32 | Source operand |
| flags_i | input | 6 | Incoming flag vector |
| result_o | output | 32 | Result, zero above the selected width |
| flags_o | output | 6 | Updated flag vector |

## Verification
Two effects land in the same evaluation during increment and decrement: the adder produces a carry out of the top bit, and the incoming carry must still be passed through. The bench provokes this collision by incrementing an all-ones word and decrementing a zero byte with CF low, and by incrementing with CF high where no wrap occurs. It then requires CF on the output to equal the incoming bit while ZF, AF and SF still follow the wrapped result. A second overlap, narrow-width arithmetic on operands with junk in the upper bits, is judged by requiring both a zero upper result and flags taken only from the selected width.

// File: rtl/alu_flags_pkg.sv
package alu_flags_pkg;

  typedef enum logic [2:0] {
    OP_OR   = 3'd0,
    OP_AND  = 3'd1,
    OP_XOR  = 3'd2,
    OP_ADD  = 3'd3,
    OP_SUB  = 3'd4,
    OP_INC  = 3'd5,
    OP_DEC  = 3'd6,
    OP_HOLD = 3'd7
  } alu_op_e;

  // msb first: of at bit 5 down to cf at bit 0
  typedef struct packed {
    logic of_f;
    logic sf_f;
    logic zf_f;
    logic af_f;
    logic pf_f;
    logic cf_f;
  } alu_flags_t;

  localparam int FLAG_W = $bits(alu_flags_t);
  localparam int AF_BIT = 4;
  localparam int PF_SPAN = 8;

endpackage

// File: rtl/alu_size_dec.sv
module alu_size_dec #(
  parameter  int BASE_W    = 8,
  parameter  int NUM_LANES = 3,
  localparam int DATA_W    = BASE_W << (NUM_LANES - 1),
  localparam int SIZE_W    = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1
) (
  input  logic [SIZE_W-1:0]    size_i,
  output logic [NUM_LANES-1:0] lane_sel_o,
  output logic [DATA_W-1:0]    lane_mask_o
);

  logic [DATA_W-1:0] lane_mask [NUM_LANES];

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    localparam int W = BASE_W << g;
    if (g == NUM_LANES - 1) begin : g_top
      // top lane also absorbs unused size codes
      assign lane_sel_o[g] = (size_i >= SIZE_W'(g));
      assign lane_mask[g]  = {DATA_W{1'b1}};
    end else begin : g_low
      assign lane_sel_o[g] = (size_i == SIZE_W'(g));
      assign lane_mask[g]  = {{(DATA_W - W){1'b0}}, {W{1'b1}}};
    end
  end

  always_comb begin
    lane_mask_o = '0;
    for (int g = 0; g < NUM_LANES; g++) begin
      lane_mask_o = lane_mask_o | (lane_mask[g] & {DATA_W{lane_sel_o[g]}});
    end
  end

endmodule

// File: rtl/alu_arith_unit.sv
module alu_arith_unit #(
  parameter  int BASE_W    = 8,
  parameter  int NUM_LANES = 3,
  localparam int DATA_W    = BASE_W << (NUM_LANES - 1)
) (
  input  logic [DATA_W-1:0]    a_i,
  input  logic [DATA_W-1:0]    b_i,
  input  logic                 sub_i,
  input  logic [NUM_LANES-1:0] lane_sel_i,
  output logic [DATA_W-1:0]    sum_o,
  output logic                 carry_o
);

  logic [DATA_W-1:0]    lane_sum [NUM_LANES];
  logic [NUM_LANES-1:0] lane_cy;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    localparam int W = BASE_W << g;
    logic [W:0] ext;
    // widened by one bit: bit W is carry on add, borrow on subtract
    assign ext = sub_i ? ({1'b0, a_i[W-1:0]} - {1'b0, b_i[W-1:0]})
                       : ({1'b0, a_i[W-1:0]} + {1'b0, b_i[W-1:0]});
    assign lane_sum[g] = DATA_W'(ext[W-1:0]);
    assign lane_cy[g]  = ext[W];
  end

  always_comb begin
    sum_o   = '0;
    carry_o = 1'b0;
    for (int g = 0; g < NUM_LANES; g++) begin
      sum_o   = sum_o | (lane_sum[g] & {DATA_W{lane_sel_i[g]}});
      carry_o = carry_o | (lane_cy[g] & lane_sel_i[g]);
    end
  end

endmodule

// File: rtl/alu_flag_gen.sv
module alu_flag_gen
  import alu_flags_pkg::*;
#(
  parameter  int BASE_W    = 8,
  parameter  int NUM_LANES = 3,
  localparam int DATA_W    = BASE_W << (NUM_LANES - 1)
) (
  input  logic [DATA_W-1:0]    res_i,
  input  logic [DATA_W-1:0]    a_i,
  input  logic [DATA_W-1:0]    b_i,
  input  logic                 sub_i,
  input  logic [NUM_LANES-1:0] lane_sel_i,
  output logic                 sf_o,
  output logic                 zf_o,
  output logic                 of_o,
  output logic                 pf_o,
  output logic                 af_o
);

  logic [NUM_LANES-1:0] lane_sf, lane_zf, lane_of;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    localparam int W = BASE_W << g;
    logic [W-1:0] ov_add, ov_sub;
    assign ov_add     = (res_i[W-1:0] ^ b_i[W-1:0]) & (res_i[W-1:0] ^ a_i[W-1:0]);
    assign ov_sub     = (a_i[W-1:0] ^ b_i[W-1:0]) & (a_i[W-1:0] ^ res_i[W-1:0]);
    assign lane_of[g] = sub_i ? ov_sub[W-1] : ov_add[W-1];
    assign lane_sf[g] = res_i[W-1];
    assign lane_zf[g] = ~|res_i[W-1:0];
  end

  assign sf_o = |(lane_sf & lane_sel_i);
  assign zf_o = |(lane_zf & lane_sel_i);
  assign of_o = |(lane_of & lane_sel_i);

  // width independent
  assign pf_o = ~^res_i[PF_SPAN-1:0];
  assign af_o = res_i[AF_BIT] ^ a_i[AF_BIT] ^ b_i[AF_BIT];

endmodule

// File: rtl/alu_flags_core.sv
module alu_flags_core
  import alu_flags_pkg::*;
#(
  parameter  int BASE_W    = 8,
  parameter  int NUM_LANES = 3,
  localparam int DATA_W    = BASE_W << (NUM_LANES - 1),
  localparam int SIZE_W    = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1
) (
  input  logic [2:0]        op_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [DATA_W-1:0] dst_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [FLAG_W-1:0] flags_i,
  output logic [DATA_W-1:0] result_o,
  output logic [FLAG_W-1:0] flags_o
);

  alu_op_e              op;
  alu_flags_t           fin, fout;
  logic                 is_logic, is_arith, is_sub, is_step;
  logic [NUM_LANES-1:0] lane_sel;
  logic [DATA_W-1:0]    lane_mask;
  logic [DATA_W-1:0]    b_opnd, logic_res, sum, res_w;
  logic                 carry;
  logic                 g_sf, g_zf, g_of, g_pf, g_af;

  assign op  = alu_op_e'(op_i);
  assign fin = alu_flags_t'(flags_i);

  assign is_logic = (op == OP_OR) || (op == OP_AND) || (op == OP_XOR);
  assign is_step  = (op == OP_INC) || (op == OP_DEC);
  assign is_sub   = (op == OP_SUB) || (op == OP_DEC);
  assign is_arith = (op == OP_ADD) || is_sub || is_step;
  assign b_opnd   = is_step ? DATA_W'(1) : src_i;

  alu_size_dec #(.BASE_W(BASE_W), .NUM_LANES(NUM_LANES)) u_size (
    .size_i      (size_i),
    .lane_sel_o  (lane_sel),
    .lane_mask_o (lane_mask)
  );

  alu_arith_unit #(.BASE_W(BASE_W), .NUM_LANES(NUM_LANES)) u_arith (
    .a_i        (dst_i),
    .b_i        (b_opnd),
    .sub_i      (is_sub),
    .lane_sel_i (lane_sel),
    .sum_o      (sum),
    .carry_o    (carry)
  );

  always_comb begin
    unique case (op)
      OP_OR:   logic_res = dst_i | src_i;
      OP_AND:  logic_res = dst_i & src_i;
      OP_XOR:  logic_res = dst_i ^ src_i;
      default: logic_res = '0;
    endcase
  end

  assign res_w = is_logic ? (logic_res & lane_mask) : sum;

  alu_flag_gen #(.BASE_W(BASE_W), .NUM_LANES(NUM_LANES)) u_flags (
    .res_i      (res_w),
    .a_i        (dst_i),
    .b_i        (b_opnd),
    .sub_i      (is_sub),
    .lane_sel_i (lane_sel),
    .sf_o       (g_sf),
    .zf_o       (g_zf),
    .of_o       (g_of),
    .pf_o       (g_pf),
    .af_o       (g_af)
  );

  always_comb begin
    fout = fin;
    if (is_logic) begin
      fout.cf_f = 1'b0;
      fout.of_f = 1'b0;
      fout.sf_f = g_sf;
      fout.zf_f = g_zf;
      fout.pf_f = g_pf;
    end else if (is_arith) begin
      fout.cf_f = is_step ? fin.cf_f : carry;
      fout.of_f = g_of;
      fout.sf_f = g_sf;
      fout.zf_f = g_zf;
      fout.pf_f = g_pf;
      fout.af_f = g_af;
    end
  end

  assign result_o = (op == OP_HOLD) ? dst_i : res_w;
  assign flags_o  = fout;

endmodule

// File: rtl/alu_flags_core_chk.sv
module alu_flags_core_chk #(
  parameter  int BASE_W    = 8,
  parameter  int NUM_LANES = 3,
  localparam int DATA_W    = BASE_W << (NUM_LANES - 1),
  localparam int SIZE_W    = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1
) (
  input logic [2:0]        op_i,
  input logic [SIZE_W-1:0] size_i,
  input logic [DATA_W-1:0] dst_i,
  input logic [DATA_W-1:0] src_i,
  input logic [5:0]        flags_i,
  input logic [DATA_W-1:0] result_o,
  input logic [5:0]        flags_o
);

  logic [DATA_W:0]   one_sh;
  logic [DATA_W-1:0] width_mask;
  int                lane;

  always_comb begin
    lane = (int'(size_i) > NUM_LANES - 1) ? NUM_LANES - 1 : int'(size_i);
    one_sh = (DATA_W + 1)'(1) << (BASE_W << lane);
    width_mask = DATA_W'(one_sh - (DATA_W + 1)'(1));
  end

  always_comb begin
    if (op_i <= 3'd2) begin
      // R8
      logic_clear_chk: assert (flags_o[0] == 1'b0 && flags_o[5] == 1'b0 && flags_o[2] == flags_i[2]);
    end
    if (op_i == 3'd5 || op_i == 3'd6) begin
      // R9
      step_carry_chk: assert (flags_o[0] == flags_i[0]);
    end
    if (op_i == 3'd7) begin
      // R11
      hold_pass_chk: assert (flags_o == flags_i && result_o == dst_i);
    end else begin
      // R7
      zero_flag_chk: assert (flags_o[3] == (result_o == '0));
      // R10
      upper_clear_chk: assert ((result_o & ~width_mask) == '0);
      // R6
      low_parity_chk: assert (flags_o[1] == ~^result_o[7:0]);
    end
  end

  logic unused_src;
  assign unused_src = ^src_i;

endmodule

bind alu_flags_core alu_flags_core_chk #(.BASE_W(BASE_W), .NUM_LANES(NUM_LANES)) u_chk (.*);

// File: tb/sim_alu_flags_core.sv
module sim_alu_flags_core;

  logic        clk = 1'b0;
  logic [2:0]  op;
  logic [1:0]  size;
  logic [31:0] dst, src, res;
  logic [5:0]  fin, fout;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  alu_flags_core u0 (
    .op_i     (op),
    .size_i   (size),
    .dst_i    (dst),
    .src_i    (src),
    .flags_i  (fin),
    .result_o (res),
    .flags_o  (fout)
  );

  // {req, op, size, dst, src, flags_in, exp_result, exp_flags}
  // flag bits: 5 OF 4 SF 3 ZF 2 AF 1 PF 0 CF
  localparam int NV = 18;
  localparam logic [120:0] VEC [NV] = '{
    {8'd3,  3'd3, 2'd0, 32'h0000007F, 32'h00000001, 6'h00, 32'h00000080, 6'h34}, // R3 byte add overflow
    {8'd2,  3'd3, 2'd0, 32'h000000FF, 32'h00000001, 6'h00, 32'h00000000, 6'h0F}, // R2 byte carry out
    {8'd7,  3'd3, 2'd1, 32'hABCDFFFF, 32'h12340001, 6'h00, 32'h00000000, 6'h0F}, // R7 zero at 16 bits
    {8'd3,  3'd3, 2'd2, 32'h7FFFFFFF, 32'h00000001, 6'h00, 32'h80000000, 6'h36}, // R3 word overflow
    {8'd2,  3'd3, 2'd2, 32'hFFFFFFFF, 32'hFFFFFFFF, 6'h00, 32'hFFFFFFFE, 6'h15}, // R2 word carry
    {8'd4,  3'd4, 2'd0, 32'h00000000, 32'h00000001, 6'h00, 32'h000000FF, 6'h17}, // R4 byte borrow
    {8'd4,  3'd4, 2'd0, 32'h00000080, 32'h00000001, 6'h00, 32'h0000007F, 6'h24}, // R4 byte sub overflow
    {8'd7,  3'd4, 2'd1, 32'h00001234, 32'h00001234, 6'h00, 32'h00000000, 6'h0A}, // R7 equal halfwords
    {8'd5,  3'd4, 2'd2, 32'h00000100, 32'h00000001, 6'h00, 32'h000000FF, 6'h06}, // R5 half borrow
    {8'd6,  3'd0, 2'd2, 32'h01000000, 32'h00000000, 6'h3F, 32'h01000000, 6'h06}, // R6 parity low byte only
    {8'd8,  3'd1, 2'd0, 32'h000000F0, 32'h0000000F, 6'h3F, 32'h00000000, 6'h0E}, // R8 and, af kept
    {8'd1,  3'd2, 2'd1, 32'h0000FFFF, 32'h00007FFF, 6'h04, 32'h00008000, 6'h16}, // R1 xor, field positions
    {8'd9,  3'd5, 2'd0, 32'h0000007F, 32'h00000055, 6'h01, 32'h00000080, 6'h35}, // R9 inc keeps cf=1
    {8'd9,  3'd5, 2'd2, 32'hFFFFFFFF, 32'h00000000, 6'h00, 32'h00000000, 6'h0E}, // R9 inc wrap keeps cf=0
    {8'd9,  3'd6, 2'd1, 32'h00008000, 32'h00000000, 6'h01, 32'h00007FFF, 6'h27}, // R9 dec overflow
    {8'd11, 3'd7, 2'd0, 32'h12345678, 32'hFFFFFFFF, 6'h2A, 32'h12345678, 6'h2A}, // R11 hold
    {8'd12, 3'd3, 2'd3, 32'h7FFFFFFF, 32'h00000001, 6'h00, 32'h80000000, 6'h36}, // R12 size 3 is word
    {8'd10, 3'd3, 2'd0, 32'h1234567F, 32'hAB000001, 6'h00, 32'h00000080, 6'h34}  // R10 upper bits cleared
  };

  task automatic check(input int req, input logic [31:0] ar, input logic [31:0] er,
                       input logic [5:0] af, input logic [5:0] ef);
    n_chk++;
    if (ar !== er || af !== ef) begin
      n_bad++;
      $display("FAIL R%0d result=%h flags=%h expected result=%h flags=%h", req, ar, af, er, ef);
    end
  endtask

  task automatic apply(input logic [2:0] o, input logic [1:0] s, input logic [31:0] d,
                       input logic [31:0] sr, input logic [5:0] f);
    @(posedge clk);
    op = o; size = s; dst = d; src = sr; fin = f;
    @(negedge clk);
  endtask

  initial begin
    op = 3'd0; size = 2'd0; dst = '0; src = '0; fin = '0;
    @(negedge clk);
    // R7 idle inputs: OR of zeros gives ZF and PF
    check(7, res, 32'h0, fout, 6'h0A);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][112:110], VEC[i][109:108], VEC[i][107:76], VEC[i][75:44], VEC[i][43:38]);
      check(int'(VEC[i][120:113]), res, VEC[i][37:6], fout, VEC[i][5:0]);
    end

    // R2 byte add sweep: result and carry
    for (int i = 0; i < 16; i++) begin
      logic [8:0] s9;
      s9 = 9'(i * 17) + 9'h9C;
      apply(3'd3, 2'd0, 32'(i * 17), 32'h9C, 6'h00);
      check(2, res, {24'h0, s9[7:0]}, {5'h0, fout[0]}, {5'h0, s9[8]});
    end

    // R4 halfword sub sweep: borrow when dst < src
    for (int i = 0; i < 12; i++) begin
      logic [15:0] d16;
      d16 = 16'(i * 16'h1555);
      apply(3'd4, 2'd1, {16'hFFFF, d16}, 32'h00007000, 6'h00);
      check(4, res, {16'h0, d16 - 16'h7000}, {5'h0, fout[0]}, {5'h0, 1'(d16 < 16'h7000)});
    end

    // R9 dec wrap at byte keeps cf=0, src ignored
    apply(3'd6, 2'd0, 32'h00000000, 32'h12345678, 6'h00);
    check(9, res, 32'h000000FF, fout, 6'h16);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule